// File: doc/BRIEF.md
# Linear-to-Floating-Point Compressor

This block takes one 13-bit two's-complement sample and compresses it, with no clock, into a 9-bit floating-point code. The code has a sign bit, a 3-bit exponent and a 5-bit significand, and it stands for the value (-1)^sign × significand × 2^exponent. The result settles in the same evaluation as the input, so the block can sit between any two registers of a sample path.

The conversion runs in four steps. The input is first turned into a sign and a magnitude. A priority search then locates the leading one of the magnitude. The search gives the exponent and selects the five significand bits. Last, the code is rounded on the single bit just below the selected field. If rounding carries out of the significand, the code is renormalised, and if the exponent then leaves its range, the code saturates at the largest value.

Top module: `fpc_compress`

## Requirements
- R1: `sign_o` equals bit 12 of `sample_i`. An input of zero gives sign 0, exponent 0 and significand 0.
- R2: A negative input is replaced by its two's-complement negation before conversion. The input -4096 (pattern 1_0000_0000_0000) has magnitude 4096 and gives sign 1, exponent 7 and significand 11111.
- R3: Let n be the number of leading zeros over all 13 input bits of the magnitude, counting the sign position. Before rounding, n = 1..7 gives exponent 8-n, and n ≥ 8 gives exponent 0.
- R4: With exponent e > 0, the significand before rounding is magnitude bits [e+4:e], so its top bit is the leading one. With e = 0, the significand is magnitude bits [4:0], and the code is not rounded.
- R5: With e > 0, magnitude bit e-1 decides rounding. If it is 0, the significand is kept. If it is 1, the significand is incremented (for example, 108 and 109 give 0_010_11011, while 110 and 111 give 0_010_11100).
- R6: If the increment carries out of 11111, the significand becomes 10000 and the exponent rises by one (253 gives 0_100_10000, and 63 gives 0_010_10000).
- R7: If the exponent would exceed 7 after rounding, the output is exponent 111 and significand 11111 (4095 gives 0_111_11111).
- R8: For every x from 1 to 4095, inputs x and -x give the same exponent and significand, and they differ only in sign (422 and -422 both give exponent 100 and significand 11010).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sample_i | input | 13 | Two's-complement linear sample |
| sign_o | output | 1 | Sign of the code |
| expo_o | output | 3 | Exponent of the code |
| mant_o | output | 5 | Significand of the code |

## Verification
Two functions can act on the same input: the rounding increment with its renormalisation, and exponent saturation. Both act when a significand of 11111 at exponent 7 is rounded up, as with inputs 4032 to 4095 and their negatives. A code at exponent 6 that carries into exponent 7 must not saturate, as with 2047. The exhaustive sweep covers every such input, and each result is judged against an arithmetic model that applies the increment, the renormalisation and the exponent limit in that order. Directed checks pin the boundary codes on both sides of the carry, including 3967 and 3968, and the bench repeats each positive code as its negative.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
    // Default field widths of the compressed code
    localparam int FPC_EXP_W = 3;
    localparam int FPC_MAN_W = 5;

    // Input width that exactly fills the exponent range
    function automatic int fpc_in_width(input int exp_w, input int man_w);
        return (1 << exp_w) + man_w;
    endfunction
endpackage

// File: rtl/fpc_magnitude.sv
module fpc_magnitude #(
    parameter int IN_W = 13
) (
    input  logic [IN_W-1:0] sample_i,
    output logic            neg_o,
    output logic [IN_W-1:0] mag_o
);
    localparam logic [IN_W-1:0] ONE     = {{(IN_W-1){1'b0}}, 1'b1};
    localparam logic [IN_W-1:0] MOST_NEG = {1'b1, {(IN_W-1){1'b0}}};

    typedef struct packed {
        logic            neg;
        logic [IN_W-1:0] mag;
    } mag_t;

    mag_t mag_d;

    always_comb begin
        mag_d.neg = sample_i[IN_W-1];
        mag_d.mag = mag_d.neg ? (~sample_i + ONE) : sample_i;
    end

    assign neg_o = mag_d.neg;
    assign mag_o = mag_d.mag;

    // Top magnitude bit only for the most negative input
    always_comb begin
        assert_mag_top_R2: assert (!mag_o[IN_W-1] || sample_i == MOST_NEG)
            else $error("magnitude top bit set for a non-extreme input");
    end
endmodule

// File: rtl/fpc_lead_find.sv
module fpc_lead_find #(
    parameter int MAG_W = 13,
    parameter int POS_W = $clog2(MAG_W)
) (
    input  logic [MAG_W-1:0] mag_i,
    output logic [POS_W-1:0] pos_o,
    output logic             nz_o
);
    logic [MAG_W-1:0] hit;

    // One-hot mark of the leading one
    genvar gi;
    generate
        for (gi = 0; gi < MAG_W; gi++) begin : g_hit
            if (gi == MAG_W - 1) begin : g_top
                assign hit[gi] = mag_i[gi];
            end else begin : g_low
                assign hit[gi] = mag_i[gi] & ~(|mag_i[MAG_W-1:gi+1]);
            end
        end
    endgenerate

    always_comb begin
        pos_o = '0;
        for (int k = 0; k < MAG_W; k++) begin
            if (hit[k]) pos_o = pos_o | POS_W'(k);
        end
        nz_o = |hit;
    end

    always_comb begin
        assert_single_lead_R3: assert ($onehot0(hit))
            else $error("more than one leading-one mark");
        assert_nonzero_R3: assert (nz_o == (mag_i != '0))
            else $error("leading-one presence disagrees with magnitude");
    end
endmodule

// File: rtl/fpc_align.sv
module fpc_align #(
    parameter int MAG_W = 13,
    parameter int POS_W = 4,
    parameter int EXP_W = 3,
    parameter int MAN_W = 5
) (
    input  logic [MAG_W-1:0] mag_i,
    input  logic [POS_W-1:0] pos_i,
    input  logic             nz_i,
    output logic [EXP_W:0]   exp_raw_o,
    output logic [MAN_W-1:0] mant_o,
    output logic             rbit_o
);
    localparam int EW1 = EXP_W + 1;

    typedef struct packed {
        logic [EXP_W:0]   expo;
        logic [MAG_W-1:0] shifted;
        logic [MAG_W-1:0] below;
    } align_t;

    align_t al_d;

    always_comb begin
        if (nz_i && int'(pos_i) >= MAN_W)
            al_d.expo = EW1'(int'(pos_i) - (MAN_W - 1));
        else
            al_d.expo = '0;
        al_d.shifted = mag_i >> al_d.expo;
        al_d.below   = (al_d.expo != '0) ? (mag_i >> (al_d.expo - 1'b1)) : '0;
    end

    assign exp_raw_o = al_d.expo;
    assign mant_o    = al_d.shifted[MAN_W-1:0];
    assign rbit_o    = al_d.below[0];

    always_comb begin
        assert_lead_bit_R4: assert (exp_raw_o == '0 || mant_o[MAN_W-1])
            else $error("significand not normalised at nonzero exponent");
        assert_no_round_at_zero_R4: assert (exp_raw_o != '0 || !rbit_o)
            else $error("round bit raised at exponent zero");
    end
endmodule

// File: rtl/fpc_round.sv
module fpc_round #(
    parameter int EXP_W = 3,
    parameter int MAN_W = 5
) (
    input  logic [EXP_W:0]   exp_raw_i,
    input  logic [MAN_W-1:0] mant_i,
    input  logic             rbit_i,
    output logic [EXP_W-1:0] exp_o,
    output logic [MAN_W-1:0] mant_o
);
    localparam logic [EXP_W:0]   EXP_MAX  = {1'b0, {EXP_W{1'b1}}};
    localparam logic [MAN_W-1:0] MAN_HALF = {1'b1, {(MAN_W-1){1'b0}}};
    localparam logic [MAN_W:0]   RB_ZERO  = '0;

    typedef struct packed {
        logic [MAN_W:0] sum;
        logic           carry;
        logic [EXP_W:0] expo;
        logic [MAN_W-1:0] mant;
        logic           sat;
    } rnd_t;

    rnd_t rnd_d;

    always_comb begin
        rnd_d.sum   = {1'b0, mant_i} + (RB_ZERO | (MAN_W+1)'(rbit_i));
        rnd_d.carry = rnd_d.sum[MAN_W];
        if (rnd_d.carry) begin
            rnd_d.mant = MAN_HALF;
            rnd_d.expo = exp_raw_i + 1'b1;
        end else begin
            rnd_d.mant = rnd_d.sum[MAN_W-1:0];
            rnd_d.expo = exp_raw_i;
        end
        rnd_d.sat = rnd_d.expo > EXP_MAX;
        if (rnd_d.sat) begin
            exp_o  = '1;
            mant_o = '1;
        end else begin
            exp_o  = rnd_d.expo[EXP_W-1:0];
            mant_o = rnd_d.mant;
        end
    end

    always_comb begin
        assert_trunc_R5: assert (rbit_i || exp_raw_i > EXP_MAX ||
                                 (mant_o == mant_i && {1'b0, exp_o} == exp_raw_i))
            else $error("code changed without a round bit");
        assert_renorm_R6: assert (!(mant_i == '1 && rbit_i) || mant_o == MAN_HALF ||
                                  (exp_o == '1 && mant_o == '1))
            else $error("carry out not renormalised");
        assert_sat_R7: assert (exp_raw_i < EXP_MAX || !(mant_i == '1 && rbit_i) ||
                               (exp_o == '1 && mant_o == '1))
            else $error("exponent overflow not saturated");
    end
endmodule

// File: rtl/fpc_compress.sv
module fpc_compress
    import fpc_pkg::*;
#(
    parameter int EXP_W = FPC_EXP_W,
    parameter int MAN_W = FPC_MAN_W,
    parameter int IN_W  = fpc_in_width(EXP_W, MAN_W)
) (
    input  logic [IN_W-1:0]  sample_i,
    output logic             sign_o,
    output logic [EXP_W-1:0] expo_o,
    output logic [MAN_W-1:0] mant_o
);
    localparam int MAG_W = IN_W;
    localparam int POS_W = $clog2(MAG_W);

    logic             neg;
    logic [MAG_W-1:0] mag;
    logic [POS_W-1:0] pos;
    logic             nz;
    logic [EXP_W:0]   exp_raw;
    logic [MAN_W-1:0] mant_raw;
    logic             rbit;

    fpc_magnitude #(.IN_W(IN_W)) u_mag (
        .sample_i (sample_i),
        .neg_o    (neg),
        .mag_o    (mag)
    );

    fpc_lead_find #(.MAG_W(MAG_W), .POS_W(POS_W)) u_lead (
        .mag_i (mag),
        .pos_o (pos),
        .nz_o  (nz)
    );

    fpc_align #(.MAG_W(MAG_W), .POS_W(POS_W), .EXP_W(EXP_W), .MAN_W(MAN_W)) u_align (
        .mag_i     (mag),
        .pos_i     (pos),
        .nz_i      (nz),
        .exp_raw_o (exp_raw),
        .mant_o    (mant_raw),
        .rbit_o    (rbit)
    );

    fpc_round #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_round (
        .exp_raw_i (exp_raw),
        .mant_i    (mant_raw),
        .rbit_i    (rbit),
        .exp_o     (expo_o),
        .mant_o    (mant_o)
    );

    assign sign_o = neg;

    always_comb begin
        assert_zero_code_R1: assert (sample_i != '0 ||
                                     (!sign_o && expo_o == '0 && mant_o == '0))
            else $error("zero input gave nonzero code");
        assert_extreme_neg_R2: assert (!mag[MAG_W-1] ||
                                       (sign_o && expo_o == '1 && mant_o == '1))
            else $error("most negative input not saturated");
    end
endmodule

// File: tb/fpc_compress_test.sv
`timescale 1ns/1ps
module fpc_compress_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [12:0] din = '0;
    logic        s;
    logic [2:0]  e;
    logic [4:0]  f;
    int          n_checks = 0;
    int          n_fail   = 0;
    int          cycles   = 0;
    bit          done     = 1'b0;

    always #4 clk = ~clk;

    fpc_compress uut (.sample_i(din), .sign_o(s), .expo_o(e), .mant_o(f));

    // Arithmetic model of the compressed code
    function automatic logic [8:0] model(input int v);
        int mag, p, ex, fr, rb;
        logic sg;
        sg  = (v < 0);
        mag = sg ? -v : v;
        p   = -1;
        for (int k = 0; k < 14; k++) if (mag >= (1 << k)) p = k;
        ex  = (p >= 5) ? p - 4 : 0;
        fr  = (mag >> ex) % 32;
        rb  = (ex > 0) ? (mag >> (ex - 1)) % 2 : 0;
        fr  = fr + rb;
        if (fr == 32) begin fr = 16; ex = ex + 1; end
        if (ex > 7) begin ex = 7; fr = 31; end
        return {sg, 3'(ex), 5'(fr)};
    endfunction

    task automatic apply(input int v);
        @(posedge clk);
        din = 13'(v);
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s in=%0d actual=%b_%b_%b expected=%b_%b_%b", req,
                     $signed(din), act[8], act[7:5], act[4:0], exp[8], exp[7:5], exp[4:0]);
        end
    endtask

    task automatic spot(input string req, input int v, input logic [8:0] exp);
        apply(v);
        check(req, {s, e, f}, exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    always @(posedge clk) cycles <= cycles + 1;

    initial begin
        logic [8:0] pos_code;
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        // R1: zero input and sign
        spot("R1", 0, 9'b0_000_00000);
        spot("R1", -1, 9'b1_000_00001);
        // R2: negation and extreme negative
        spot("R2", -4096, 9'b1_111_11111);
        spot("R2", -4095, 9'b1_111_11111);
        // R3/R4: exponent and significand selection
        spot("R3", 422, 9'b0_100_11010);
        spot("R4", 31, 9'b0_000_11111);
        spot("R4", 1, 9'b0_000_00001);
        // R5: round on bit below the significand
        spot("R5", 108, 9'b0_010_11011);
        spot("R5", 109, 9'b0_010_11011);
        spot("R5", 110, 9'b0_010_11100);
        spot("R5", 111, 9'b0_010_11100);
        spot("R5", 3967, 9'b0_111_11111);
        spot("R5", 3968, 9'b0_111_11111);
        // R6: renormalisation after carry
        spot("R6", 253, 9'b0_100_10000);
        spot("R6", 63, 9'b0_010_10000);
        spot("R6", 2047, 9'b0_111_10000);
        // R7: saturation
        spot("R7", 4095, 9'b0_111_11111);
        spot("R7", 4032, 9'b0_111_11111);
        // R8: sign symmetry
        spot("R8", -422, 9'b1_100_11010);
        // R3 R4 R5 R6 R7: exhaustive sweep against the model
        for (int v = -4096; v < 4096; v++) begin
            apply(v);
            check("R3-sweep", {s, e, f}, model(v));
        end
        // R8: x and -x share exponent and significand
        for (int v = 1; v < 4096; v++) begin
            apply(v);
            pos_code = {s, e, f};
            apply(-v);
            check("R8", {s, e, f}, {1'b1, pos_code[7:0]});
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule